// File: doc/BRIEF.md
# Status-Flag Arithmetic Logic Unit

This block is the integer datapath core of a small processor. It takes two operands, an incoming carry and the current status flags, an operation code and a width select, and it produces a result with a write-enable, a per-flag update mask and the next status flags. The result, write-enable and update mask are combinational. The next flags are captured in a register on each clock edge and appear on `flags_q` in the following cycle.

Each operation decides which of the six flags it changes. A flag that the operation does not update is copied from `flags_in`, so the surrounding pipeline can always write `flags_q` back to its architectural flag state. Examples: increment and decrement keep the carry, bitwise complement keeps every flag, and the compare-style AND (test) updates flags without writing a result.

In narrow mode only the low half of each operand takes part. All flags come from that low half, and the upper half of the result is driven to zero.

Top module: `flag_alu`

## Requirements
- R1: The flag vector is {overflow[5], sign[4], zero[3], aux[2], parity[1], carry[0]}. `flags_q` is 0 on the cycle after a synchronous active-low reset. In every other cycle it holds the next-flag value computed from the inputs seen at the previous rising edge.
- R2: The opcodes are add=0, add-with-carry=1, subtract=2, subtract-with-borrow=3. They produce A+B, A+B+cin, A−B and A−B−cin. For the subtract forms, carry means a borrow out of the top bit (02h−03h gives FFh with carry 1). `carry_in` is ignored by add and subtract.
- R3: Overflow is set when the signed result is out of range. For 8 bits, 7Fh+1 and 80h−1 set it. For 16 bits, 7FFFh+1 sets overflow and clears carry, and FFFEh+3 sets carry and clears overflow.
- R4: Zero is set when the active-width result is 0. Sign is the top bit of the active width. Parity is 1 when result bits 7:0 hold an even number of ones. Aux is the carry (or, for subtract forms, the borrow) out of bit 3.
- R5: Increment (4) and decrement (5) compute A+1 and A−1 and ignore B. They update all flags except carry, which keeps `flags_in[0]`.
- R6: Negate (6) computes 0−A and updates all flags. Carry is set exactly when the active-width operand is nonzero.
- R7: AND (7), OR (8) and XOR (9) write the bitwise result. They clear carry, overflow and aux, and they update zero, sign and parity.
- R8: Complement (10) writes ~A and changes no flag: `flag_upd` is 0 and the next flags equal `flags_in`.
- R9: Test (11) drives A AND B on `result`, holds `result_we` at 0, and updates the flags exactly as AND does.
- R10: With `wide`=0, result bits 15:8 are 0 and every flag is computed from bits 7:0 only.
- R11: Opcodes 12 to 15 hold `result_we` and `flag_upd` at 0, drive `result` to 0, and pass `flags_in` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 16 | First operand (destination value) |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry/borrow for the chained forms |
| flags_in | input | 6 | Current flags, passed through where not updated |
| opcode | input | 4 | Operation select |
| wide | input | 1 | 1: 16-bit operation, 0: 8-bit operation |
| result | output | 16 | Operation result |
| result_we | output | 1 | Result should be written back |
| flag_upd | output | 6 | Per-flag update mask, same bit order as flags |
| flags_q | output | 6 | Registered next flags |

## Verification
Two functions can coincide in one cycle: computing a fresh flag and preserving a stale one. Increment with `flags_in` carry set, a logic operation with every incoming flag set, and complement with an arbitrary incoming pattern all combine an updated subset with a kept subset. The bench drives these cases with deliberately chosen incoming flags. It then compares the whole registered flag vector one edge later, so both a wrongly kept bit and a wrongly updated bit are caught.

// File: rtl/flag_alu_pkg.sv
// Shared opcode codes and flag bit positions for the status-flag ALU.
// Assumes consumers index the flag vector with the FI_* constants.
package flag_alu_pkg;

    localparam int FLAG_N = 6;

    localparam int FI_CF = 0;
    localparam int FI_PF = 1;
    localparam int FI_AF = 2;
    localparam int FI_ZF = 3;
    localparam int FI_SF = 4;
    localparam int FI_OF = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_NEG  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_NOT  = 4'd10,
        OP_TEST = 4'd11
    } alu_op_e;

    localparam logic [FLAG_N-1:0] UPD_ALL   = 6'b111111;
    localparam logic [FLAG_N-1:0] UPD_NO_CF = 6'b111110;
    localparam logic [FLAG_N-1:0] UPD_NONE  = 6'b000000;

endpackage

// File: rtl/alu_addsub.sv
// Adder/subtractor with carry-in and selectable narrow/wide flag taps.
// Assumes: subtraction is x + ~y + ~bin; carry and aux are reported as
// borrows when sub=1. Overflow is taken at the active top bit.
module alu_addsub #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int AUX_BIT  = 4
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              sub,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              cf,
    output logic              of,
    output logic              af
);
    logic [DATA_W-1:0] y_eff;
    logic              c_eff;
    logic [DATA_W:0]   full;
    logic [DATA_W:0]   cin_vec;
    logic              c_top;
    logic              c_below;

    // Operand conditioning for two's complement subtraction.
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
    end

    // Sum and carry into every bit position.
    always_comb begin
        full    = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
        cin_vec = full ^ {1'b0, x} ^ {1'b0, y_eff};
        sum     = full[DATA_W-1:0];
    end

    // Flag taps at the active width.
    always_comb begin
        c_top   = wide ? cin_vec[DATA_W]   : cin_vec[NARROW_W];
        c_below = wide ? cin_vec[DATA_W-1] : cin_vec[NARROW_W-1];
        cf      = c_top ^ sub;
        of      = c_top ^ c_below;
        af      = cin_vec[AUX_BIT] ^ sub;
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR, XOR and complement of the operands.
// Assumes the caller selects its output only for logic opcodes.
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    output logic [DATA_W-1:0] y
);
    // Select the bitwise function for the opcode.
    always_comb begin
        case (op)
            OP_AND, OP_TEST: y = a & b;
            OP_OR:           y = a | b;
            OP_XOR:          y = a ^ b;
            OP_NOT:          y = ~a;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flaggen.sv
// Builds the candidate flag vector from a result and the adder taps.
// Assumes the result is already masked to the active width and that
// logic operations want carry, overflow and aux forced to zero.
module alu_flaggen
    import flag_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int PAR_W    = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    input  logic              is_logic,
    input  logic              add_cf,
    input  logic              add_of,
    input  logic              add_af,
    output logic [FLAG_N-1:0] gen
);
    // Status flags from the result, arithmetic flags from the adder.
    always_comb begin
        gen        = '0;
        gen[FI_ZF] = wide ? (res == '0) : (res[NARROW_W-1:0] == '0);
        gen[FI_SF] = wide ? res[DATA_W-1] : res[NARROW_W-1];
        gen[FI_PF] = ~^res[PAR_W-1:0];
        gen[FI_CF] = is_logic ? 1'b0 : add_cf;
        gen[FI_OF] = is_logic ? 1'b0 : add_of;
        gen[FI_AF] = is_logic ? 1'b0 : add_af;
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Flag register: merges updated and kept flags and stores them.
// Assumes synchronous active-low reset to all-zero flags.
module alu_flag_reg
    import flag_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] gen,
    input  logic [FLAG_N-1:0] keep,
    input  logic [FLAG_N-1:0] upd,
    output logic [FLAG_N-1:0] q
);
    logic [FLAG_N-1:0] nxt;

    // Per-bit choice between the new and the incoming flag.
    always_comb begin
        nxt = (gen & upd) | (keep & ~upd);
    end

    // Capture the merged flags each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/flag_alu.sv
// Top level of the status-flag ALU: decodes the opcode, steers the
// adder and bitwise unit, masks to the selected width, and registers
// the merged flags. Assumes NARROW_W >= 8 so parity has 8 bits to read.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic                carry_in,
    input  logic [FLAG_N-1:0]   flags_in,
    input  logic [3:0]          opcode,
    input  logic                wide,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [FLAG_N-1:0]   flag_upd,
    output logic [FLAG_N-1:0]   flags_q
);
    localparam int UPPER_W = DATA_W - NARROW_W;
    localparam int PAR_W   = 8;
    localparam int AUX_BIT = 4;

    logic [DATA_W-1:0] add_x, add_y, add_sum, log_y, raw, masked;
    logic              add_c, add_sub, add_cf, add_of, add_af;
    logic              is_arith, is_logic;
    logic [FLAG_N-1:0] gen;

    // Operand routing and mode decode for each opcode.
    always_comb begin
        add_x    = opnd_a;
        add_y    = opnd_b;
        add_c    = 1'b0;
        add_sub  = 1'b0;
        is_arith = 1'b0;
        is_logic = 1'b0;
        case (opcode)
            OP_ADD:  is_arith = 1'b1;
            OP_ADC:  begin is_arith = 1'b1; add_c = carry_in; end
            OP_SUB:  begin is_arith = 1'b1; add_sub = 1'b1; end
            OP_SBB:  begin is_arith = 1'b1; add_sub = 1'b1; add_c = carry_in; end
            OP_INC:  begin is_arith = 1'b1; add_y = DATA_W'(1); end
            OP_DEC:  begin is_arith = 1'b1; add_y = DATA_W'(1); add_sub = 1'b1; end
            OP_NEG:  begin is_arith = 1'b1; add_x = '0; add_y = opnd_a; add_sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_TEST, OP_NOT: is_logic = 1'b1;
            default: ;
        endcase
    end

    // Write-enable and per-flag update mask.
    always_comb begin
        case (opcode)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: begin
                result_we = 1'b1; flag_upd = UPD_ALL;
            end
            OP_INC, OP_DEC: begin
                result_we = 1'b1; flag_upd = UPD_NO_CF;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_we = 1'b1; flag_upd = UPD_ALL;
            end
            OP_TEST: begin
                result_we = 1'b0; flag_upd = UPD_ALL;
            end
            OP_NOT: begin
                result_we = 1'b1; flag_upd = UPD_NONE;
            end
            default: begin
                result_we = 1'b0; flag_upd = UPD_NONE;
            end
        endcase
    end

    alu_addsub #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .AUX_BIT  (AUX_BIT)
    ) u_addsub (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_c),
        .sub  (add_sub),
        .wide (wide),
        .sum  (add_sum),
        .cf   (add_cf),
        .of   (add_of),
        .af   (add_af)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (opcode),
        .y  (log_y)
    );

    // Pick the unit output for the opcode class.
    always_comb begin
        if (is_arith)      raw = add_sum;
        else if (is_logic) raw = log_y;
        else               raw = '0;
    end

    // Zero the upper part when the narrow width is selected.
    generate
        if (UPPER_W > 0) begin : g_mask
            always_comb begin
                masked = wide ? raw : {{UPPER_W{1'b0}}, raw[NARROW_W-1:0]};
            end
        end else begin : g_nomask
            always_comb begin
                masked = raw;
            end
        end
    endgenerate

    assign result = masked;

    alu_flaggen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .PAR_W    (PAR_W)
    ) u_flaggen (
        .res      (masked),
        .wide     (wide),
        .is_logic (is_logic),
        .add_cf   (add_cf),
        .add_of   (add_of),
        .add_af   (add_af),
        .gen      (gen)
    );

    alu_flag_reg u_flag_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .gen   (gen),
        .keep  (flags_in),
        .upd   (flag_upd),
        .q     (flags_q)
    );
endmodule

// File: rtl/flag_alu_chk.sv
// Checker for flag_alu, attached by bind. Relates the decoded opcode,
// the combinational outputs and the registered flags one edge later.
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   opnd_a,
    input logic [FLAG_N-1:0]   flags_in,
    input logic [3:0]          opcode,
    input logic                wide,
    input logic [DATA_W-1:0]   result,
    input logic                result_we,
    input logic [FLAG_N-1:0]   flag_upd,
    input logic [FLAG_N-1:0]   flags_q
);
    // R8: complement keeps every flag
    a_r8_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_NOT) |=> (flags_q == $past(flags_in)));

    // R7: logic ops leave carry and overflow clear
    a_r7_logic_clears_cf_of: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
        |=> (!flags_q[FI_CF] && !flags_q[FI_OF]));

    // R9: test never writes
    a_r9_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_TEST) |-> !result_we);

    // R5: increment/decrement keep carry
    a_r5_incdec_keep_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_INC || opcode == OP_DEC)
        |=> (flags_q[FI_CF] == $past(flags_in[FI_CF])));

    // R11: empty update mask passes the incoming flags
    a_r11_no_upd_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd == '0) |=> (flags_q == $past(flags_in)));

    // R10: narrow mode clears upper result bits
    a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (result[DATA_W-1:NARROW_W] == '0));

    // R4: registered zero flag matches the written result
    a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && flag_upd[FI_ZF] && wide)
        |=> (flags_q[FI_ZF] == ($past(result) == '0)));

    // R6: negate of a nonzero wide operand borrows
    a_r6_neg_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_NEG && wide && opnd_a != '0) |=> flags_q[FI_CF]);
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .flags_in  (flags_in),
    .opcode    (opcode),
    .wide      (wide),
    .result    (result),
    .result_we (result_we),
    .flag_upd  (flag_upd),
    .flags_q   (flags_q)
);

// File: tb/flag_alu_test.sv
// Vector-table bench for flag_alu followed by reset and timing checks.
module flag_alu_test;
    localparam int NV = 22;
    // Fields: req[70:67] op[66:63] wide[62] a[61:46] b[45:30]
    //         cin[29] fin[28:23] res[22:7] we[6] flags[5:0]
    // Flags: {OF,SF,ZF,AF,PF,CF}
    localparam logic [70:0] VECS [NV] = '{
        // R3 8-bit 7F+1
        {4'd3, 4'd0, 1'b0, 16'h007F, 16'h0001, 1'b0, 6'b000000, 16'h0080, 1'b1, 6'b110100},
        // R3 8-bit 80-1
        {4'd3, 4'd2, 1'b0, 16'h0080, 16'h0001, 1'b0, 6'b000000, 16'h007F, 1'b1, 6'b100100},
        // R2 02-03 borrow
        {4'd2, 4'd2, 1'b0, 16'h0002, 16'h0003, 1'b0, 6'b000000, 16'h00FF, 1'b1, 6'b010111},
        // R2 22-34
        {4'd2, 4'd2, 1'b0, 16'h0022, 16'h0034, 1'b0, 6'b000000, 16'h00EE, 1'b1, 6'b010111},
        // R3 16-bit FFFE+3
        {4'd3, 4'd0, 1'b1, 16'hFFFE, 16'h0003, 1'b0, 6'b000000, 16'h0001, 1'b1, 6'b000101},
        // R3 16-bit 7FFF+1
        {4'd3, 4'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0, 6'b000000, 16'h8000, 1'b1, 6'b110110},
        // R2 add-with-carry FFFF+0+1
        {4'd2, 4'd1, 1'b1, 16'hFFFF, 16'h0000, 1'b1, 6'b000000, 16'h0000, 1'b1, 6'b001111},
        // R2 subtract-with-borrow 10-0F-1
        {4'd2, 4'd3, 1'b0, 16'h0010, 16'h000F, 1'b1, 6'b000000, 16'h0000, 1'b1, 6'b001110},
        // R2 plain add ignores carry_in
        {4'd2, 4'd0, 1'b0, 16'h0001, 16'h0001, 1'b1, 6'b000000, 16'h0002, 1'b1, 6'b000000},
        // R5 inc FF keeps CF=1, B ignored
        {4'd5, 4'd4, 1'b0, 16'h00FF, 16'h1234, 1'b0, 6'b000001, 16'h0000, 1'b1, 6'b001111},
        // R5 dec 8000 keeps CF=0
        {4'd5, 4'd5, 1'b1, 16'h8000, 16'h0000, 1'b0, 6'b000000, 16'h7FFF, 1'b1, 6'b100110},
        // R6 negate zero
        {4'd6, 4'd6, 1'b0, 16'h0000, 16'h0000, 1'b0, 6'b000001, 16'h0000, 1'b1, 6'b001010},
        // R6 negate one
        {4'd6, 4'd6, 1'b0, 16'h0001, 16'h0000, 1'b0, 6'b000000, 16'h00FF, 1'b1, 6'b010111},
        // R7 and with all flags set
        {4'd7, 4'd7, 1'b0, 16'h0035, 16'h006D, 1'b0, 6'b111111, 16'h0025, 1'b1, 6'b000000},
        // R7 or
        {4'd7, 4'd8, 1'b0, 16'h0035, 16'h006D, 1'b0, 6'b111111, 16'h007D, 1'b1, 6'b000010},
        // R7 xor wide
        {4'd7, 4'd9, 1'b1, 16'h8035, 16'h006D, 1'b0, 6'b111111, 16'h8058, 1'b1, 6'b010000},
        // R8 complement keeps flags
        {4'd8, 4'd10, 1'b1, 16'h00FF, 16'h0000, 1'b0, 6'b101010, 16'hFF00, 1'b1, 6'b101010},
        // R9 test: flags only
        {4'd9, 4'd11, 1'b0, 16'h000F, 16'h00F0, 1'b0, 6'b110101, 16'h0000, 1'b0, 6'b001010},
        // R11 unused opcode
        {4'd11, 4'd15, 1'b1, 16'h1234, 16'h4321, 1'b1, 6'b011001, 16'h0000, 1'b0, 6'b011001},
        // R10 narrow: upper bytes dropped
        {4'd10, 4'd0, 1'b0, 16'h12FF, 16'h3401, 1'b0, 6'b000000, 16'h0000, 1'b1, 6'b001111},
        // R10 narrow complement
        {4'd10, 4'd10, 1'b0, 16'h1235, 16'h0000, 1'b0, 6'b000000, 16'h00CA, 1'b1, 6'b000000},
        // R4 wide aux carry, parity of low byte
        {4'd4, 4'd0, 1'b1, 16'h00FF, 16'h0001, 1'b0, 6'b000000, 16'h0100, 1'b1, 6'b000110}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [5:0]  flags_in = '0;
    logic [3:0]  opcode = 4'd15;
    logic        wide = 1'b0;
    logic [15:0] result;
    logic        result_we;
    logic [5:0]  flag_upd;
    logic [5:0]  flags_q;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_alu uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .flags_in(flags_in), .opcode(opcode), .wide(wide),
        .result(result), .result_we(result_we), .flag_upd(flag_upd), .flags_q(flags_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", 32'(flags_q), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v[70:67], i);
            opcode = v[66:63]; wide = v[62]; opnd_a = v[61:46]; opnd_b = v[45:30];
            carry_in = v[29]; flags_in = v[28:23];
            #1;
            chk({tag, " result"}, 32'(result), 32'(v[22:7]));
            chk({tag, " we"}, 32'(result_we), 32'(v[6]));
            @(negedge clk);
            chk({tag, " flags"}, 32'(flags_q), 32'(v[5:0]));
        end
        // R1: flags_q holds the old value until the edge
        opcode = 4'd10; flags_in = 6'b010101;
        @(negedge clk);
        opcode = 4'd10; flags_in = 6'b101010;
        #1;
        chk("R1 flags before edge", 32'(flags_q), 32'h15);
        @(negedge clk);
        chk("R1 flags after edge", 32'(flags_q), 32'h2A);
        // R1: reset mid-run clears flags
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", 32'(flags_q), 32'h0);
        rst_n = 1'b1;
        // R8: complement update mask is empty
        #1;
        chk("R8 complement mask", 32'(flag_upd), 32'h0);
        // R5: increment mask excludes carry
        opcode = 4'd4;
        #1;
        chk("R5 increment mask", 32'(flag_upd), 32'h3E);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule